// File: doc/BRIEF.md
# Instruction-Fetch Deadman Timer

This block supervises software that is expected to service it at regular intervals. It counts the processor's instruction fetches, not clock cycles. If the count reaches a programmed period before the software has serviced it, the block raises a reset request for the system reset controller. No instruction fetches happen while the processor sleeps, so no counting happens then either.

Software services the timer in two steps through a small register bus. First it writes an arming key into the pre-clear register. Then it writes a release key into the clear register. The second step is accepted only while the service window is open. The window opens once the fetch count has reached the programmed window start, and it stays open until the count reaches the period. Three things are flagged as errors: a wrong arming key, a release key that arrives unarmed or too early, and a wrong release key. Every such error raises the same event and reset request as a timeout. Once the timer is enabled, only a system reset can stop it.

Top module: `ifdm_deadman`

## Requirements
- R1: After reset the enable bit, count, period, window start and all status bits are zero, `rst_req` is low, and a read of any register returns zero.
- R2: Writing 1 to bit 15 of the control register (offset 0x00) sets the enable bit. A later write of 0 does not clear it; only `rst` does. The count never advances while the bit is clear.
- R3: While the timer is enabled, not sleeping and not tripped, the count (offset 0x40) goes up by exactly one in each clock cycle in which `ifetch` is high.
- R4: A cycle in which `sleep` is high does not advance the count, even if `ifetch` is high.
- R5: When a counted fetch brings the count to the value of the period register (offset 0x60), status bit 5 is set and `rst_req` rises on the same edge. From then on the count stays frozen, and both stay set until `rst`.
- R6: Status bit 0 (offset 0x30) is 1 exactly when the timer is enabled, no event is flagged, and the count is greater than or equal to the window start register (offset 0x70).
- R7: Writing 0x40 in bits 15:8 to offset 0x10, and then 0x08 in bits 7:0 to offset 0x20 while status bit 0 is 1, sets the count to zero and sets no status bit. The arming is used up, so a further release key needs a new arming key first.
- R8: A write to offset 0x10 whose bits 15:8 are not 0x40 sets status bit 7 and status bit 5, and raises `rst_req`.
- R9: A write to offset 0x20 sets status bit 6 and status bit 5, and raises `rst_req`, if the timer is not armed, if the window is closed, or if bits 7:0 are not 0x08. Any write to offset 0x20 uses up the arming.
- R10: Writes to offsets 0x10 and 0x20 while the enable bit is clear have no effect on the status bits or on `rst_req`.
- R11: A bus write or read in the first clock cycle after `rst` is released is ignored.
- R12: Read data appears on `bus_rdata` one cycle after `bus_rd`. The period and window start registers read back what was written to them. Offsets 0x10 and 0x20 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous system reset, active high |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | DATA_W | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | DATA_W | Read data, valid the cycle after `bus_rd` |
| ifetch | input | 1 | Instruction-fetch strobe |
| sleep | input | 1 | Processor sleep indication |
| rst_req | output | 1 | Reset request, sticky until `rst` |

## Verification
The bench targets the release key sent too early, sent without arming, and sent with a wrong value. A design that checks only the key value would accept these and silently reset the count instead of tripping. It also drives fetches together with `sleep`. A design that ignores the sleep gate would trip early. A fetch that reaches the period must trip on that exact edge, and the count must then stay frozen. A design that overshoots or keeps counting shows up on the count readback. Finally, the bench tries to clear the enable bit, writes keys while the timer is disabled, and makes an access in the cycle right after reset. A design that honours any of these would run with no supervision or flag a false error.

// File: rtl/ifdm_pkg.sv
package ifdm_pkg;

   localparam logic [7:0] OFS_CTRL   = 8'h00;
   localparam logic [7:0] OFS_ARM    = 8'h10;
   localparam logic [7:0] OFS_KICK   = 8'h20;
   localparam logic [7:0] OFS_STAT   = 8'h30;
   localparam logic [7:0] OFS_COUNT  = 8'h40;
   localparam logic [7:0] OFS_PERIOD = 8'h60;
   localparam logic [7:0] OFS_WIN    = 8'h70;

   localparam int EN_BIT      = 15;
   localparam int ST_OPEN     = 0;
   localparam int ST_EVENT    = 5;
   localparam int ST_BADKICK  = 6;
   localparam int ST_BADARM   = 7;

   localparam logic [7:0] ARM_KEY  = 8'h40;
   localparam logic [7:0] KICK_KEY = 8'h08;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_CTRL,
      SEL_ARM,
      SEL_KICK,
      SEL_STAT,
      SEL_COUNT,
      SEL_PERIOD,
      SEL_WIN
   } reg_sel_e;

   typedef struct packed {
      logic bad_arm;
      logic bad_kick;
      logic event_hit;
      logic open;
   } status_t;

endpackage

// File: rtl/ifdm_regif.sv
module ifdm_regif
   import ifdm_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 32,
   parameter int READ_LAT = 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              wr,
   input  logic              rd,
   input  status_t           st,
   input  logic [DATA_W-1:0] count,
   output logic              enable,
   output logic [DATA_W-1:0] period,
   output logic [DATA_W-1:0] window,
   output logic              arm_wr,
   output logic              kick_wr,
   output logic              acc_ok,
   output logic [DATA_W-1:0] rdata
);

   localparam int PAD_W = ADDR_W - 8;

   logic        guard_q;
   reg_sel_e    sel;
   logic        wr_ok;
   logic        rd_ok;
   logic [DATA_W-1:0] rd_val;
   logic [DATA_W-1:0] stat_vec;
   logic [DATA_W-1:0] ctrl_vec;

   // the first cycle after reset release is a dead cycle for the bus
   always_ff @(posedge clk) begin
      if (rst) guard_q <= 1'b1;
      else     guard_q <= 1'b0;
   end

   assign acc_ok = !guard_q;
   assign wr_ok  = acc_ok && wr;
   assign rd_ok  = acc_ok && rd;

   function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] ofs);
      return a == {{PAD_W{1'b0}}, ofs};
   endfunction

   always_comb begin
      sel = SEL_NONE;
      if      (hit(addr, OFS_CTRL))   sel = SEL_CTRL;
      else if (hit(addr, OFS_ARM))    sel = SEL_ARM;
      else if (hit(addr, OFS_KICK))   sel = SEL_KICK;
      else if (hit(addr, OFS_STAT))   sel = SEL_STAT;
      else if (hit(addr, OFS_COUNT))  sel = SEL_COUNT;
      else if (hit(addr, OFS_PERIOD)) sel = SEL_PERIOD;
      else if (hit(addr, OFS_WIN))    sel = SEL_WIN;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         enable <= 1'b0;
         period <= '0;
         window <= '0;
      end else if (wr_ok) begin
         if (sel == SEL_CTRL && wdata[EN_BIT]) enable <= 1'b1;
         if (sel == SEL_PERIOD) period <= wdata;
         if (sel == SEL_WIN)    window <= wdata;
      end
   end

   // key writes only reach the sequencer while the timer runs
   assign arm_wr  = wr_ok && enable && (sel == SEL_ARM);
   assign kick_wr = wr_ok && enable && (sel == SEL_KICK);

   always_comb begin
      stat_vec = '0;
      stat_vec[ST_OPEN]    = st.open;
      stat_vec[ST_EVENT]   = st.event_hit;
      stat_vec[ST_BADKICK] = st.bad_kick;
      stat_vec[ST_BADARM]  = st.bad_arm;
      ctrl_vec = '0;
      ctrl_vec[EN_BIT] = enable;
   end

   always_comb begin
      unique case (sel)
         SEL_CTRL:   rd_val = ctrl_vec;
         SEL_STAT:   rd_val = stat_vec;
         SEL_COUNT:  rd_val = count;
         SEL_PERIOD: rd_val = period;
         SEL_WIN:    rd_val = window;
         default:    rd_val = '0;
      endcase
   end

   generate
      if (READ_LAT == 1) begin : g_rd_reg
         logic [DATA_W-1:0] rdata_q;
         always_ff @(posedge clk) begin
            if (rst)        rdata_q <= '0;
            else if (rd_ok) rdata_q <= rd_val;
            else            rdata_q <= '0;
         end
         assign rdata = rdata_q;
      end else begin : g_rd_comb
         assign rdata = rd_ok ? rd_val : '0;
      end
   endgenerate

endmodule

// File: rtl/ifdm_keyseq.sv
module ifdm_keyseq
   import ifdm_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       arm_wr,
   input  logic       kick_wr,
   input  logic [7:0] arm_val,
   input  logic [7:0] kick_val,
   input  logic       win_open,
   output logic       bad_arm,
   output logic       bad_kick,
   output logic       kick_ok,
   output logic       bad_now
);

   logic armed;
   logic arm_good;

   assign arm_good = arm_wr && (arm_val == ARM_KEY);
   assign kick_ok  = kick_wr && armed && win_open && (kick_val == KICK_KEY);
   assign bad_now  = (arm_wr && !arm_good) || (kick_wr && !kick_ok);

   always_ff @(posedge clk) begin
      if (rst) begin
         armed    <= 1'b0;
         bad_arm  <= 1'b0;
         bad_kick <= 1'b0;
      end else begin
         if (arm_wr)                armed    <= arm_good;
         else if (kick_wr)          armed    <= 1'b0;
         if (arm_wr && !arm_good)   bad_arm  <= 1'b1;
         if (kick_wr && !kick_ok)   bad_kick <= 1'b1;
      end
   end

endmodule

// File: rtl/ifdm_counter.sv
module ifdm_counter #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              enable,
   input  logic              ifetch,
   input  logic              sleep,
   input  logic [DATA_W-1:0] period,
   input  logic [DATA_W-1:0] window,
   input  logic              kick_ok,
   input  logic              bad_now,
   output logic [DATA_W-1:0] count,
   output logic              event_hit,
   output logic              win_open
);

   logic              step;
   logic [DATA_W-1:0] cnt_inc;

   assign step    = enable && ifetch && !sleep && !event_hit;
   assign cnt_inc = count + {{(DATA_W-1){1'b0}}, 1'b1};

   always_ff @(posedge clk) begin
      if (rst) begin
         count     <= '0;
         event_hit <= 1'b0;
      end else begin
         if (kick_ok) begin
            count <= '0;
         end else if (step) begin
            count <= cnt_inc;
            if (cnt_inc == period) event_hit <= 1'b1;
         end
         if (bad_now) event_hit <= 1'b1;
      end
   end

   assign win_open = enable && !event_hit && (count >= window);

endmodule

// File: rtl/ifdm_deadman.sv
module ifdm_deadman
   import ifdm_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 32,
   parameter int READ_LAT = 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_wr,
   input  logic              bus_rd,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              ifetch,
   input  logic              sleep,
   output logic              rst_req
);

   generate
      if (ADDR_W < 8) begin : g_bad_addr
         $error("ifdm_deadman: ADDR_W must be at least 8");
      end
      if (DATA_W < 16 || DATA_W > 32) begin : g_bad_data
         $error("ifdm_deadman: DATA_W must lie in 16..32");
      end
      if (READ_LAT != 0 && READ_LAT != 1) begin : g_bad_lat
         $error("ifdm_deadman: READ_LAT must be 0 or 1");
      end
   endgenerate

   logic              enable;
   logic [DATA_W-1:0] period;
   logic [DATA_W-1:0] window;
   logic [DATA_W-1:0] count;
   logic              arm_wr;
   logic              kick_wr;
   logic              acc_ok;
   logic              kick_ok;
   logic              bad_now;
   logic              bad_arm;
   logic              bad_kick;
   logic              event_hit;
   logic              win_open;
   status_t           st;

   assign st.bad_arm   = bad_arm;
   assign st.bad_kick  = bad_kick;
   assign st.event_hit = event_hit;
   assign st.open      = win_open;

   ifdm_regif #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .READ_LAT (READ_LAT)
   ) u_reg (
      .clk     (clk),
      .rst     (rst),
      .addr    (bus_addr),
      .wdata   (bus_wdata),
      .wr      (bus_wr),
      .rd      (bus_rd),
      .st      (st),
      .count   (count),
      .enable  (enable),
      .period  (period),
      .window  (window),
      .arm_wr  (arm_wr),
      .kick_wr (kick_wr),
      .acc_ok  (acc_ok),
      .rdata   (bus_rdata)
   );

   ifdm_keyseq u_key (
      .clk      (clk),
      .rst      (rst),
      .arm_wr   (arm_wr),
      .kick_wr  (kick_wr),
      .arm_val  (bus_wdata[15:8]),
      .kick_val (bus_wdata[7:0]),
      .win_open (win_open),
      .bad_arm  (bad_arm),
      .bad_kick (bad_kick),
      .kick_ok  (kick_ok),
      .bad_now  (bad_now)
   );

   ifdm_counter #(
      .DATA_W (DATA_W)
   ) u_cnt (
      .clk       (clk),
      .rst       (rst),
      .enable    (enable),
      .ifetch    (ifetch),
      .sleep     (sleep),
      .period    (period),
      .window    (window),
      .kick_ok   (kick_ok),
      .bad_now   (bad_now),
      .count     (count),
      .event_hit (event_hit),
      .win_open  (win_open)
   );

   assign rst_req = event_hit;

endmodule

// File: rtl/ifdm_chk.sv
module ifdm_chk
   import ifdm_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              bus_wr,
   input logic              sleep,
   input logic              rst_req,
   input logic              enable,
   input logic              acc_ok,
   input logic              win_open,
   input logic [DATA_W-1:0] count
);

   localparam int PAD_W = ADDR_W - 8;

   // R5
   req_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      rst_req |=> rst_req);

   // R2
   enable_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      enable |=> enable);

   // R2
   idle_no_req_chk: assert property (@(posedge clk) disable iff (rst)
      !enable |-> !rst_req);

   // R4
   sleep_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (sleep && !(bus_wr && bus_addr == {{PAD_W{1'b0}}, OFS_KICK}))
      |=> count == $past(count));

   // R6
   closed_on_event_chk: assert property (@(posedge clk) disable iff (rst)
      rst_req |-> !win_open);

   // R8
   bad_arm_trip_chk: assert property (@(posedge clk) disable iff (rst)
      (acc_ok && enable && bus_wr && bus_addr == {{PAD_W{1'b0}}, OFS_ARM}
       && bus_wdata[15:8] != ARM_KEY) |=> rst_req);

endmodule

bind ifdm_deadman ifdm_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_wr    (bus_wr),
   .sleep     (sleep),
   .rst_req   (rst_req),
   .enable    (enable),
   .acc_ok    (acc_ok),
   .win_open  (win_open),
   .count     (count)
);

// File: tb/sim_ifdm_deadman.sv
`timescale 1ns/1ps
module sim_ifdm_deadman;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_rdata;
   logic        ifetch = 1'b0;
   logic        sleep = 1'b0;
   logic        rst_req;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   string cur_req = "R1";

   always #2.5 clk = ~clk;

   ifdm_deadman u0 (
      .clk       (clk),
      .rst       (rst),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_rdata (bus_rdata),
      .ifetch    (ifetch),
      .sleep     (sleep),
      .rst_req   (rst_req)
   );

   // behavioural reference model
   bit          m_en, m_armed, m_badarm, m_badkick, m_ev, m_guard;
   logic [31:0] m_cnt, m_per, m_win, m_rd;

   function automatic logic [31:0] m_read(input logic [7:0] a);
      logic [31:0] v = 0;
      case (a)
         8'h00: v[15] = m_en;
         8'h30: begin
            v[0] = m_en && !m_ev && (m_cnt >= m_win);
            v[5] = m_ev; v[6] = m_badkick; v[7] = m_badarm;
         end
         8'h40: v = m_cnt;
         8'h60: v = m_per;
         8'h70: v = m_win;
         default: v = 0;
      endcase
      return v;
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         m_en = 0; m_armed = 0; m_badarm = 0; m_badkick = 0; m_ev = 0;
         m_guard = 1; m_cnt = 0; m_per = 0; m_win = 0; m_rd = 0;
      end else begin
         bit ok, open, armw, kickw, kick_good, bad;
         ok = !m_guard;
         m_guard = 0;
         m_rd = (ok && bus_rd) ? m_read(bus_addr) : 32'h0;
         open  = m_en && !m_ev && (m_cnt >= m_win);
         armw  = ok && bus_wr && m_en && bus_addr == 8'h10;
         kickw = ok && bus_wr && m_en && bus_addr == 8'h20;
         kick_good = kickw && m_armed && open && bus_wdata[7:0] == 8'h08;
         bad = (armw && bus_wdata[15:8] != 8'h40) || (kickw && !kick_good);
         if (kick_good) m_cnt = 0;
         else if (m_en && ifetch && !sleep && !m_ev) begin
            m_cnt = m_cnt + 1;
            if (m_cnt == m_per) m_ev = 1;
         end
         if (bad) m_ev = 1;
         if (armw && bus_wdata[15:8] != 8'h40) m_badarm = 1;
         if (kickw && !kick_good) m_badkick = 1;
         if (armw) m_armed = (bus_wdata[15:8] == 8'h40);
         else if (kickw) m_armed = 0;
         if (ok && bus_wr) begin
            if (bus_addr == 8'h00 && bus_wdata[15]) m_en = 1;
            if (bus_addr == 8'h60) m_per = bus_wdata;
            if (bus_addr == 8'h70) m_win = bus_wdata;
         end
      end
   end

   // per-cycle comparison of the reset request
   always @(negedge clk) begin
      cycles++;
      if (!rst) begin
         checks++;
         if (rst_req !== m_ev) begin
            fails++;
            $display("FAIL %s rst_req actual %0b expected %0b", cur_req, rst_req, m_ev);
         end
      end
   end

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 0; bus_wdata = 0;
   endtask

   task automatic rd(input logic [7:0] a, input string tag, output logic [31:0] v);
      @(negedge clk);
      bus_rd = 1; bus_addr = a;
      @(negedge clk);
      bus_rd = 0;
      v = bus_rdata;
      chk(bus_rdata, m_rd, {tag, " model"});
   endtask

   task automatic fetch(input int n, input bit slp);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         ifetch = 1; sleep = slp;
      end
      @(negedge clk);
      ifetch = 0; sleep = 0;
   endtask

   task automatic do_reset();
      @(negedge clk); rst = 1; bus_wr = 0; bus_rd = 0; ifetch = 0; sleep = 0;
      @(negedge clk);
      @(negedge clk); rst = 0;
   endtask

   task automatic setup(input logic [31:0] per, input logic [31:0] win);
      wr(8'h60, per);
      wr(8'h70, win);
      wr(8'h00, 32'h8000);
   endtask

   initial begin
      logic [31:0] v;
      // R1 reset state
      cur_req = "R1";
      do_reset();
      chk({31'h0, rst_req}, 32'h0, "R1 rst_req");
      rd(8'h30, "R1", v); chk(v, 32'h0, "R1 status");
      rd(8'h00, "R1", v); chk(v, 32'h0, "R1 ctrl");

      // R10 keys while disabled
      cur_req = "R10";
      wr(8'h10, 32'h1200);
      wr(8'h20, 32'h0077);
      rd(8'h30, "R10", v); chk(v, 32'h0, "R10 status after keys");

      // R11 guarded first cycle
      cur_req = "R11";
      @(negedge clk); rst = 1;
      @(negedge clk);
      @(negedge clk); rst = 0; bus_wr = 1; bus_addr = 8'h00; bus_wdata = 32'h8000;
      @(negedge clk); bus_wr = 0; bus_wdata = 0;
      rd(8'h00, "R11", v); chk(v, 32'h0, "R11 ctrl ignored");

      // R12 readback, R2 enable sticky
      cur_req = "R12";
      setup(32'd20, 32'd10);
      rd(8'h60, "R12", v); chk(v, 32'd20, "R12 period");
      rd(8'h70, "R12", v); chk(v, 32'd10, "R12 window");
      rd(8'h10, "R12", v); chk(v, 32'h0, "R12 preclear reads zero");
      cur_req = "R2";
      wr(8'h00, 32'h0);
      rd(8'h00, "R2", v); chk(v, 32'h8000, "R2 enable sticky");

      // R3 counting, R4 sleep
      cur_req = "R3";
      fetch(7, 0);
      rd(8'h40, "R3", v); chk(v, 32'd7, "R3 count");
      cur_req = "R4";
      fetch(6, 1);
      rd(8'h40, "R4", v); chk(v, 32'd7, "R4 count held in sleep");
      rd(8'h30, "R6", v); chk(v, 32'h0, "R6 window closed below start");

      // R6 window opens, R7 good service
      cur_req = "R6";
      fetch(5, 0);
      rd(8'h30, "R6", v); chk(v, 32'h1, "R6 window open");
      cur_req = "R7";
      wr(8'h10, 32'h4000);
      wr(8'h20, 32'h0008);
      rd(8'h40, "R7", v); chk(v, 32'h0, "R7 count cleared");
      rd(8'h30, "R7", v); chk(v, 32'h0, "R7 status clean");

      // R9 release key without arming (arm was used up)
      cur_req = "R9";
      fetch(12, 0);
      wr(8'h20, 32'h0008);
      rd(8'h30, "R9", v); chk(v, 32'h60, "R9 unarmed kick");

      // R9 release key while window closed
      do_reset(); @(negedge clk);
      setup(32'd20, 32'd10);
      fetch(3, 0);
      wr(8'h10, 32'h4000);
      wr(8'h20, 32'h0008);
      rd(8'h30, "R9", v); chk(v, 32'h60, "R9 early kick");
      rd(8'h40, "R9", v); chk(v, 32'd3, "R9 count kept");

      // R9 wrong release value in window
      do_reset(); @(negedge clk);
      setup(32'd20, 32'd2);
      fetch(4, 0);
      wr(8'h10, 32'h4000);
      wr(8'h20, 32'h0009);
      rd(8'h30, "R9", v); chk(v, 32'h60, "R9 wrong kick value");

      // R8 wrong arming value
      cur_req = "R8";
      do_reset(); @(negedge clk);
      setup(32'd20, 32'd2);
      wr(8'h10, 32'h4100);
      rd(8'h30, "R8", v); chk(v, 32'hA0, "R8 bad arm");

      // R5 timeout on exact count, then frozen
      cur_req = "R5";
      do_reset(); @(negedge clk);
      setup(32'd20, 32'd10);
      fetch(19, 0);
      chk({31'h0, rst_req}, 32'h0, "R5 no trip before period");
      fetch(1, 0);
      chk({31'h0, rst_req}, 32'h1, "R5 trip at period");
      fetch(5, 0);
      rd(8'h40, "R5", v); chk(v, 32'd20, "R5 count frozen");
      rd(8'h30, "R5", v); chk(v, 32'h20, "R5 status event");

      // R5 service and count collide: count at period-1 is still serviceable
      do_reset(); @(negedge clk);
      setup(32'd8, 32'd4);
      fetch(7, 0);
      wr(8'h10, 32'h4000);
      wr(8'h20, 32'h0008);
      rd(8'h40, "R7", v); chk(v, 32'h0, "R7 late service");
      chk({31'h0, rst_req}, 32'h0, "R5 no trip after service");

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      wait (cycles > 100000);
      fails++;
      $display("FAIL watchdog actual %0d expected below 100000 cycles", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule